// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used translations from a virtual page number to a physical frame number. It sits in front of a page table walker. Every lookup presents a 32-bit virtual address. The upper 20 bits, which are the virtual page number, are compared in parallel against the tag of every valid entry. On a hit, the block returns the physical address in the same cycle. That address is the stored frame number joined to the untouched 12-bit page offset. The block then marks the entry as referenced and, for a store, as dirty. On a miss it raises a request to the walker. The walker later writes the translation through the fill port.

A fill goes to one of three entries, in this order of preference:
1. The entry that already holds the same tag, so no duplicate is ever created.
2. Otherwise, the lowest-numbered invalid entry.
3. Otherwise, the entry named by a round-robin pointer.

One invalidate-all pulse empties the whole buffer in one cycle.

The lookup port has a valid qualifier and no ready. A lookup is always accepted and answered combinationally, so it never sees back-pressure. The fill port is valid/ready. A fill transfers on a cycle where both fill_valid and fill_ready are high. fill_ready drops during reset and during any cycle with inv_all high. A fill offered in such a cycle is not taken and must be held or offered again.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses (lk_hit = 0) and fill_ready is 1 when inv_all is 0.
- R2: A lookup with lk_valid = 1 whose page number (lk_vaddr[31:12]) equals the tag of a valid entry gives, in the same cycle, lk_hit = 1, lk_way = that entry's index, and lk_paddr = {frame number, lk_vaddr[11:0]}. With lk_valid = 0, lk_hit is 0.
- R3: walk_req is 1 exactly when lk_valid = 1 and the lookup misses.
- R4: A hit sets the entry's reference bit from the next cycle on. lk_ref shows the bit as it stood before the current lookup.
- R5: A hit with lk_write = 1 also sets the entry's dirty bit from the next cycle on. lk_dirty shows the bit as it stood before the current lookup.
- R6: A fill whose tag is absent goes to the lowest-numbered invalid entry when one exists.
- R7: A fill whose tag is absent, made while all entries are valid, replaces the entry named by a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping from 7 to 0, only on such replacements.
- R8: A fill whose tag matches a valid entry rewrites that entry's frame number in place and leaves the round-robin pointer unchanged. No two valid entries ever hold the same tag.
- R9: An inv_all cycle invalidates every entry, so every lookup in the next cycle misses. fill_ready is 0 in that cycle, and a fill offered then is not taken.
- R10: A taken fill makes its entry valid from the next cycle, with reference and dirty bits cleared. In the fill cycle it takes precedence over a hit update on the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | The access is a store (sets dirty on hit) |
| lk_hit | output | 1 | Translation found |
| lk_way | output | 3 | Index of the entry that hit |
| lk_paddr | output | 32 | Physical address on hit |
| lk_ref | output | 1 | Reference bit of the hit entry before this access |
| lk_dirty | output | 1 | Dirty bit of the hit entry before this access |
| walk_req | output | 1 | Miss: request a page table walk |
| fill_valid | input | 1 | Fill request offered |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_pfn | input | 20 | Physical frame number to install |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The first directed pattern fills the buffer through its free entries in ascending order. Looking each entry up again then shows whether placement follows the lowest-free rule or some other order. Repeated reads and stores to one page separate the reference-bit update from the dirty-bit update. Further fills are made once the buffer is full, both with new tags and with an already-present tag. These show whether replacement is round-robin, and whether an overwrite leaves the pointer alone and avoids a duplicate. An invalidate pulse with a fill offered in the same cycle, followed by fresh fills, checks both that the refused fill is really refused and that the free search restarts at entry 0. A long random mix then runs over a page set larger than the buffer, with occasional invalidates. It is compared every cycle against a behavioural model, so eviction order, bit updates and same-cycle hit/fill collisions are tried in many combinations.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    PICK_MATCH = 2'd0,
    PICK_FREE  = 2'd1,
    PICK_ROBIN = 2'd2
  } pick_e;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             hit_upd,
  input  logic             hit_wr,
  input  logic [VPN_W-1:0] probe_vpn,
  output logic             probe_match,
  output logic             fill_match,
  output logic             valid_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic             acc_o,
  output logic             dirty_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] pfn_q;
  logic             acc_q;
  logic             dirty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      pfn_q   <= '0;
      acc_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      if (clr_all) valid_q <= 1'b0;
      if (wr_en) begin
        valid_q <= 1'b1;
        vpn_q   <= wr_vpn;
        pfn_q   <= wr_pfn;
        acc_q   <= 1'b0;
        dirty_q <= 1'b0;
      end else if (hit_upd) begin
        acc_q <= 1'b1;
        if (hit_wr) dirty_q <= 1'b1;
      end
    end
  end

  assign probe_match = valid_q && (vpn_q == probe_vpn);
  assign fill_match  = valid_q && (vpn_q == wr_vpn);
  assign valid_o     = valid_q;
  assign pfn_o       = pfn_q;
  assign acc_o       = acc_q;
  assign dirty_o     = dirty_q;
endmodule

// File: rtl/tlb_hit_mux.sv
module tlb_hit_mux #(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            hit_vec,
  input  logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr,
  input  logic [ENTRIES-1:0]            acc_arr,
  input  logic [ENTRIES-1:0]            dirty_arr,
  output logic [IDX_W-1:0]              hit_idx,
  output logic [PFN_W-1:0]              hit_pfn,
  output logic                          hit_acc,
  output logic                          hit_dirty
);
  always_comb begin
    hit_idx   = '0;
    hit_pfn   = '0;
    hit_acc   = 1'b0;
    hit_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        hit_pfn   = hit_pfn | pfn_arr[i];
        hit_acc   = hit_acc | acc_arr[i];
        hit_dirty = hit_dirty | dirty_arr[i];
      end
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [ENTRIES-1:0] fmatch,
  input  logic [ENTRIES-1:0] valid,
  output logic [ENTRIES-1:0] tgt_sel,
  output pick_e              pick
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] tgt_idx;
  logic             found_m;
  logic             found_f;

  always_comb begin
    found_m = 1'b0;
    found_f = 1'b0;
    pick    = PICK_ROBIN;
    tgt_idx = rr_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found_m && fmatch[i]) begin
        found_m = 1'b1;
        tgt_idx = IDX_W'(i);
        pick    = PICK_MATCH;
      end
    end
    if (!found_m) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!found_f && !valid[i]) begin
          found_f = 1'b1;
          tgt_idx = IDX_W'(i);
          pick    = PICK_FREE;
        end
      end
    end
  end

  assign tgt_sel = fire ? (ENTRIES'(1) << tgt_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (fire && pick == PICK_ROBIN) begin
      if (rr_q == IDX_W'(ENTRIES - 1)) rr_q <= '0;
      else rr_q <= rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_way,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_ref,
  output logic             lk_dirty,
  output logic             walk_req,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             inv_all
);
  import tlb_pkg::*;

  logic [VPN_W-1:0]            probe_vpn;
  logic [ENTRIES-1:0]          hit_vec;
  logic [ENTRIES-1:0]          fmatch_vec;
  logic [ENTRIES-1:0]          valid_vec;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr;
  logic [ENTRIES-1:0]          acc_arr;
  logic [ENTRIES-1:0]          dirty_arr;
  logic [ENTRIES-1:0]          tgt_sel;
  logic [PFN_W-1:0]            hit_pfn;
  logic                        any_hit;
  logic                        fill_fire;
  pick_e                       pick;

  assign probe_vpn  = lk_vaddr[VA_W-1:OFF_W];
  assign fill_ready = !rst && !inv_all;
  assign fill_fire  = fill_valid && fill_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .clr_all    (inv_all),
      .wr_en      (tgt_sel[g]),
      .wr_vpn     (fill_vpn),
      .wr_pfn     (fill_pfn),
      .hit_upd    (lk_valid && hit_vec[g]),
      .hit_wr     (lk_write),
      .probe_vpn  (probe_vpn),
      .probe_match(hit_vec[g]),
      .fill_match (fmatch_vec[g]),
      .valid_o    (valid_vec[g]),
      .pfn_o      (pfn_arr[g]),
      .acc_o      (acc_arr[g]),
      .dirty_o    (dirty_arr[g])
    );
  end

  tlb_hit_mux #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_mux (
    .hit_vec  (hit_vec),
    .pfn_arr  (pfn_arr),
    .acc_arr  (acc_arr),
    .dirty_arr(dirty_arr),
    .hit_idx  (lk_way),
    .hit_pfn  (hit_pfn),
    .hit_acc  (lk_ref),
    .hit_dirty(lk_dirty)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk    (clk),
    .rst    (rst),
    .fire   (fill_fire),
    .fmatch (fmatch_vec),
    .valid  (valid_vec),
    .tgt_sel(tgt_sel),
    .pick   (pick)
  );

  assign any_hit  = |hit_vec;
  assign lk_hit   = lk_valid && any_hit;
  assign walk_req = lk_valid && !any_hit;
  assign lk_paddr = {hit_pfn, lk_vaddr[OFF_W-1:0]};
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     lk_valid,
  input logic [VA_W-1:0]          lk_vaddr,
  input logic                     lk_write,
  input logic                     lk_hit,
  input logic [PA_W-1:0]          lk_paddr,
  input logic                     lk_ref,
  input logic                     lk_dirty,
  input logic                     fill_valid,
  input logic                     fill_ready,
  input logic [VA_W-OFF_W-1:0]    fill_vpn,
  input logic [PA_W-OFF_W-1:0]    fill_pfn,
  input logic                     inv_all,
  input logic [ENTRIES-1:0]       hit_vec
);
  // R8: a tag is never present twice
  a_r8_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R9: nothing survives an invalidate
  a_r9_inv_empties: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> !lk_hit);

  // R10: a taken fill is visible next cycle with clean status bits
  a_r10_fill_visible: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_valid && fill_ready) && lk_valid &&
     lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn))
    |-> (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_pfn) && !lk_ref && !lk_dirty));

  // R4: a hit leaves the reference bit set
  a_r4_ref_sticks: assert property (@(posedge clk) disable iff (rst)
    ($past(lk_hit && !fill_valid && !inv_all) && lk_valid &&
     lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W]))
    |-> (lk_hit && lk_ref));

  // R5: a store hit leaves the dirty bit set
  a_r5_dirty_sticks: assert property (@(posedge clk) disable iff (rst)
    ($past(lk_hit && lk_write && !fill_valid && !inv_all) && lk_valid &&
     lk_vaddr[VA_W-1:OFF_W] == $past(lk_vaddr[VA_W-1:OFF_W]))
    |-> (lk_hit && lk_dirty));
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 1'b0;
  logic        lk_hit;
  logic [2:0]  lk_way;
  logic [31:0] lk_paddr;
  logic        lk_ref;
  logic        lk_dirty;
  logic        walk_req;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        inv_all = 1'b0;

  tlb_fa dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_v[N];
  logic [19:0] m_vpn[N];
  logic [19:0] m_pfn[N];
  bit          m_ref[N];
  bit          m_dirty[N];
  int          m_rr;

  // last observed outputs
  logic        o_hit, o_ref, o_dirty, o_walk, o_fready;
  logic [2:0]  o_way;
  logic [31:0] o_paddr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_ref[i] = 0; m_dirty[i] = 0;
    end
    m_rr = 0;
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit w,
                      input bit fv, input logic [19:0] fvpn, input logic [19:0] fpfn,
                      input bit inv);
    int h;
    int t;
    bit e_hit;
    bit robin;
    @(negedge clk);
    lk_valid = v; lk_vaddr = a; lk_write = w;
    fill_valid = fv; fill_vpn = fvpn; fill_pfn = fpfn; inv_all = inv;
    #1;
    o_hit = lk_hit; o_way = lk_way; o_paddr = lk_paddr; o_ref = lk_ref;
    o_dirty = lk_dirty; o_walk = walk_req; o_fready = fill_ready;
    h = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == a[31:12]) h = i;
    e_hit = v && (h >= 0);
    chk(o_hit === e_hit, "R2 hit", {31'd0, o_hit}, {31'd0, e_hit});
    chk(o_walk === (v && !e_hit), "R3 walk_req", {31'd0, o_walk}, {31'd0, v && !e_hit});
    chk(o_fready === !inv, "R9 fill_ready", {31'd0, o_fready}, {31'd0, !inv});
    if (e_hit) begin
      chk(o_way === 3'(h), "R2 way", {29'd0, o_way}, h);
      chk(o_paddr === {m_pfn[h], a[11:0]}, "R2 paddr", o_paddr, {m_pfn[h], a[11:0]});
      chk(o_ref === m_ref[h], "R4 ref", {31'd0, o_ref}, {31'd0, m_ref[h]});
      chk(o_dirty === m_dirty[h], "R5 dirty", {31'd0, o_dirty}, {31'd0, m_dirty[h]});
    end
    @(posedge clk);
    // pick fill target from pre-edge state
    t = -1; robin = 0;
    if (fv && !inv) begin
      for (int i = 0; i < N; i++) if (t < 0 && m_v[i] && m_vpn[i] == fvpn) t = i;
      if (t < 0) for (int i = 0; i < N; i++) if (t < 0 && !m_v[i]) t = i;
      if (t < 0) begin t = m_rr; robin = 1; end
    end
    if (e_hit) begin
      m_ref[h] = 1;
      if (w) m_dirty[h] = 1;
    end
    if (inv) for (int i = 0; i < N; i++) m_v[i] = 0;
    if (t >= 0) begin
      m_v[t] = 1; m_vpn[t] = fvpn; m_pfn[t] = fpfn; m_ref[t] = 0; m_dirty[t] = 0;
      if (robin) m_rr = (m_rr + 1) % N;
    end
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off, input bit w);
    step(1, {vpn, off}, w, 0, '0, '0, 0);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
    step(0, '0, 0, 1, vpn, pfn, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: empty after reset
    look(20'h00001, 12'h000, 0);
    chk(o_hit === 1'b0, "R1 miss after reset", {31'd0, o_hit}, 0);
    chk(o_walk === 1'b1, "R1 walk after reset", {31'd0, o_walk}, 1);
    chk(o_fready === 1'b1, "R1 fill_ready", {31'd0, o_fready}, 1);

    // R6: free entries used in ascending order
    for (int i = 0; i < N; i++) fill(20'h00010 + 20'(i), 20'h000A0 + 20'(i));
    look(20'h00013, 12'h0AB, 0);
    chk(o_hit === 1'b1 && o_way === 3'd3, "R6 placement way", {29'd0, o_way}, 3);
    chk(o_paddr === 32'h000A30AB, "R2 paddr", o_paddr, 32'h000A30AB);
    chk(o_ref === 1'b0 && o_dirty === 1'b0, "R10 clean bits", {30'd0, o_ref, o_dirty}, 0);
    look(20'h00017, 12'h000, 0);
    chk(o_way === 3'd7, "R6 placement way", {29'd0, o_way}, 7);

    // R4/R5
    look(20'h00013, 12'h000, 0);
    chk(o_ref === 1'b1 && o_dirty === 1'b0, "R4 ref after read", {30'd0, o_ref, o_dirty}, 2);
    look(20'h00013, 12'h004, 1);
    chk(o_dirty === 1'b0, "R5 dirty before store", {31'd0, o_dirty}, 0);
    look(20'h00013, 12'h008, 0);
    chk(o_dirty === 1'b1, "R5 dirty after store", {31'd0, o_dirty}, 1);

    // R7: round robin once full
    fill(20'h00020, 20'h000B0);
    look(20'h00020, 12'h000, 0);
    chk(o_way === 3'd0, "R7 first replacement", {29'd0, o_way}, 0);
    look(20'h00010, 12'h000, 0);
    chk(o_hit === 1'b0 && o_walk === 1'b1, "R7 evicted miss", {30'd0, o_hit, o_walk}, 1);
    fill(20'h00021, 20'h000B1);
    look(20'h00021, 12'h000, 0);
    chk(o_way === 3'd1, "R7 second replacement", {29'd0, o_way}, 1);

    // R8: overwrite in place, pointer untouched
    fill(20'h00013, 20'h000C3);
    look(20'h00013, 12'h010, 0);
    chk(o_way === 3'd3 && o_paddr === 32'h000C3010, "R8 overwrite", o_paddr, 32'h000C3010);
    chk(o_ref === 1'b0 && o_dirty === 1'b0, "R8 bits cleared", {30'd0, o_ref, o_dirty}, 0);
    fill(20'h00022, 20'h000B2);
    look(20'h00022, 12'h000, 0);
    chk(o_way === 3'd2, "R8 pointer kept", {29'd0, o_way}, 2);

    // R9: invalidate with a fill offered
    step(0, '0, 0, 1, 20'h00030, 20'h000D0, 1);
    chk(o_fready === 1'b0, "R9 ready low", {31'd0, o_fready}, 0);
    look(20'h00030, 12'h000, 0);
    chk(o_hit === 1'b0, "R9 refused fill", {31'd0, o_hit}, 0);
    look(20'h00021, 12'h000, 0);
    chk(o_hit === 1'b0, "R9 all invalid", {31'd0, o_hit}, 0);

    // R6 after invalidate
    fill(20'h00040, 20'h000E0);
    fill(20'h00041, 20'h000E1);
    look(20'h00041, 12'h000, 0);
    chk(o_way === 3'd1, "R6 refill way", {29'd0, o_way}, 1);

    // R10: same-cycle hit and fill on the same entry
    step(1, {20'h00040, 12'h000}, 1, 1, 20'h00040, 20'h000F0, 0);
    look(20'h00040, 12'h000, 0);
    chk(o_paddr === 32'h000F0000 && o_dirty === 1'b0, "R10 fill wins", o_paddr, 32'h000F0000);

    // random mix, model compared every cycle
    for (int k = 0; k < 3000; k++) begin
      logic [19:0] rv;
      logic [19:0] fvn;
      int r;
      rv  = 20'h00050 + 20'($urandom_range(0, 11));
      fvn = 20'h00050 + 20'($urandom_range(0, 11));
      r = $urandom_range(0, 99);
      step($urandom_range(0, 9) < 7, {rv, 12'($urandom)}, $urandom_range(0, 2) == 0,
           r < 30, fvn, 20'($urandom), r == 99);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule